// File: doc/BRIEF.md
# Tagged Geometric-History Direction Predictor

This block guesses whether a conditional branch will be taken. It holds one untagged bimodal base table and a set of tagged tables. Tagged table n looks at the newest 2^n outcomes of a global history register, so the history lengths are 2, 4, 8, 16, 32 and 64 bits for tables 1 to 6. On a lookup, every tagged table forms an index and a partial tag from the PC hashed with its slice of history, and all tables are probed at once. The longest-history table whose tag matches supplies the prediction. The next one down supplies an alternate prediction.

When a branch resolves, the front end sends the outcome back together with the provider number, the prediction and the alternate prediction it received at lookup. The block then trains the provider's counter and adjusts its usefulness. After a misprediction it claims a free entry in a longer-history table, or wears down the usefulness of the entries that blocked that claim. Last, it shifts the outcome into the history.

Top module: `tage_predictor`

## Requirements
- R1: After reset, every base counter is 01 (weakly not taken), no tagged entry is valid and the history is all zeros, so a lookup returns taken=0, provider=0 and alternate=0.
- R2: The base table holds 2-bit counters indexed by pc[BASE_IDX_W-1:0]. A counter predicts taken when its value is 2 or 3, and it saturates at 0 and 3.
- R3: Tagged table n uses the newest L=2^n history bits, with history bit 0 as the newest outcome. Its index is pc[IDX_W-1:0] with each history bit k (k<L) XOR-ed into index bit k mod IDX_W. Its tag is pc[IDX_W+TAG_W-1:IDX_W] with each history bit k XOR-ed into tag bit k mod TAG_W. An entry hits when it is valid and its stored tag equals the computed tag.
- R4: The provider is the highest-numbered tagged table that hits, or 0 when none hits. The prediction is bit 1 of the provider's counter.
- R5: The alternate prediction comes from the second-highest hitting tagged table. When only one tagged table hits, or none, it comes from the base table.
- R6: On an update, only the provider's counter (the base counter when provider=0) moves one step toward the outcome, saturating at 0 and 3.
- R7: When a tagged provider's prediction and alternate differ, its 2-bit usefulness counter steps up if the prediction matched the outcome and steps down otherwise, saturating at 0 and 3.
- R8: On a misprediction, the lowest-numbered table above the provider whose indexed entry has usefulness 0 is claimed. An invalid entry counts as usefulness 0. The claimed entry becomes valid, takes the computed tag, gets counter 10 for taken or 01 for not taken, and gets usefulness 0. Only one entry is claimed per update.
- R9: On a misprediction where no table above the provider has a free entry, the usefulness of the indexed entry in every table above the provider drops by one.
- R10: Each update shifts its outcome into history bit 0. The history does not change without an update.
- R11: A lookup presented in one cycle is answered in the next cycle with rsp_valid high. rsp_valid is low in a cycle after no lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | PC to predict |
| rsp_valid | output | 1 | Lookup answer valid (one cycle later) |
| rsp_taken | output | 1 | Final direction prediction |
| rsp_provider | output | PROV_W | Provider table number, 0 = base |
| rsp_alt_taken | output | 1 | Alternate prediction |
| up_valid | input | 1 | Resolved branch update |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome |
| up_provider | input | PROV_W | Provider number returned at lookup |
| up_pred | input | 1 | Prediction returned at lookup |
| up_alt | input | 1 | Alternate returned at lookup |

## Verification
The predictor is driven with four kinds of branch stream, and every answer is compared with an arithmetic model of the tables.

- **Single always-taken branch:** shows that the base counter saturates and that one allocation climbs into table 1.
- **Alternating branch:** only the 2-bit history can separate its two cases, so it tests the hash and the choice of the longest hit.
- **Four interleaved branches with a period-three outcome:** build up entries in several tables, which tests the alternate selection and the usefulness training.
- **Pseudo-random PCs and outcomes:** mispredict often. This fills tables until no entry is free and exercises the usefulness wear-down path.

// File: rtl/tage_pkg.sv
package tage_pkg;

  // history length used by tagged table n (n >= 1)
  function automatic int hist_len(input int n);
    return 1 << n;
  endfunction

  // saturating 2-bit step toward up/down
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

endpackage

// File: rtl/tage_hash.sv
module tage_hash #(
  parameter int PC_W  = 10,
  parameter int HLEN  = 2,
  parameter int IDX_W = 4,
  parameter int TAG_W = 6
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [HLEN-1:0]  hist,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  // fold the history slice onto index and tag widths, then mix in the PC
  always_comb begin
    idx = pc[IDX_W-1:0];
    tag = pc[IDX_W+TAG_W-1:IDX_W];
    for (int k = 0; k < HLEN; k++) begin
      idx[k % IDX_W] ^= hist[k];
      tag[k % TAG_W] ^= hist[k];
    end
  end
endmodule

// File: rtl/tage_base.sv
module tage_base import tage_pkg::*; #(
  parameter  int IDX_W = 5,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_pred,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  logic [1:0] ctr [DEPTH];

  assign rd_pred = ctr[rd_idx][1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr[i] <= 2'b01;
    end else if (we) begin
      ctr[wr_idx] <= ctr_step(ctr[wr_idx], wr_taken);
    end
  end

  // R2
  base_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wr_taken && ctr[wr_idx] == 2'b11) |=> ctr[$past(wr_idx)] == 2'b11);
endmodule

// File: rtl/tage_bank.sv
module tage_bank #(
  parameter  int IDX_W = 4,
  parameter  int TAG_W = 6,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic             rd_pred,
  input  logic [IDX_W-1:0] up_idx,
  input  logic [TAG_W-1:0] up_tag,
  output logic [1:0]       up_ctr,
  output logic [1:0]       up_u,
  input  logic             we_ctr,
  input  logic [1:0]       ctr_in,
  input  logic             we_u,
  input  logic [1:0]       u_in,
  input  logic             alloc
);
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [1:0]       ctr_mem [DEPTH];
  logic [1:0]       u_mem   [DEPTH];
  logic [DEPTH-1:0] vld;

  assign rd_hit  = vld[rd_idx] && (tag_mem[rd_idx] == rd_tag);
  assign rd_pred = ctr_mem[rd_idx][1];
  assign up_ctr  = ctr_mem[up_idx];
  assign up_u    = vld[up_idx] ? u_mem[up_idx] : 2'b00;

  // data arrays carry no reset
  always_ff @(posedge clk) begin
    if (we_ctr) ctr_mem[up_idx] <= ctr_in;
    if (we_u)   u_mem[up_idx]   <= u_in;
    if (alloc)  tag_mem[up_idx] <= up_tag;
  end

  always_ff @(posedge clk) begin
    if (rst)        vld <= '0;
    else if (alloc) vld[up_idx] <= 1'b1;
  end

  // R8
  alloc_free_chk: assert property (@(posedge clk) disable iff (rst)
    alloc |-> up_u == 2'b00);
  // R1
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (vld & $past(vld)) == $past(vld));
endmodule

// File: rtl/tage_predictor.sv
module tage_predictor import tage_pkg::*; #(
  parameter  int PC_W       = 10,
  parameter  int BASE_IDX_W = 5,
  parameter  int IDX_W      = 4,
  parameter  int TAG_W      = 6,
  parameter  int NUM_TAGGED = 6,
  localparam int PROV_W     = $clog2(NUM_TAGGED + 1),
  localparam int GHR_W      = 1 << NUM_TAGGED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              rsp_valid,
  output logic              rsp_taken,
  output logic [PROV_W-1:0] rsp_provider,
  output logic              rsp_alt_taken,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic              up_taken,
  input  logic [PROV_W-1:0] up_provider,
  input  logic              up_pred,
  input  logic              up_alt
);
  logic [GHR_W-1:0]      ghr;
  logic [NUM_TAGGED-1:0] lk_hit, lk_pred, cand, alloc, decay;
  logic [1:0]            ub_ctr [NUM_TAGGED];
  logic [1:0]            ub_u   [NUM_TAGGED];
  logic                  base_pred, mispred;
  logic                  sel_pred, sel_alt;
  logic [PROV_W-1:0]     sel_prov;

  assign mispred = up_valid && (up_pred != up_taken);
  // lowest-numbered free candidate wins
  assign alloc   = cand & (~cand + NUM_TAGGED'(1));

  tage_base #(.IDX_W(BASE_IDX_W)) u_base (
    .clk(clk), .rst(rst),
    .rd_idx(lk_pc[BASE_IDX_W-1:0]), .rd_pred(base_pred),
    .we(up_valid && up_provider == '0),
    .wr_idx(up_pc[BASE_IDX_W-1:0]), .wr_taken(up_taken)
  );

  for (genvar t = 0; t < NUM_TAGGED; t++) begin : g_tab
    localparam int TNUM = t + 1;
    localparam int HL   = hist_len(TNUM);
    logic [IDX_W-1:0] li, ui;
    logic [TAG_W-1:0] lt, ut;
    logic             is_prov, we_c, we_u;
    logic [1:0]       c_in, u_in;

    tage_hash #(.PC_W(PC_W), .HLEN(HL), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lk_hash (
      .pc(lk_pc), .hist(ghr[HL-1:0]), .idx(li), .tag(lt));
    tage_hash #(.PC_W(PC_W), .HLEN(HL), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_up_hash (
      .pc(up_pc), .hist(ghr[HL-1:0]), .idx(ui), .tag(ut));

    tage_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_bank (
      .clk(clk), .rst(rst),
      .rd_idx(li), .rd_tag(lt), .rd_hit(lk_hit[t]), .rd_pred(lk_pred[t]),
      .up_idx(ui), .up_tag(ut), .up_ctr(ub_ctr[t]), .up_u(ub_u[t]),
      .we_ctr(we_c), .ctr_in(c_in), .we_u(we_u), .u_in(u_in), .alloc(alloc[t])
    );

    assign cand[t]  = mispred && (TNUM > int'(up_provider)) && (ub_u[t] == 2'b00);
    assign decay[t] = mispred && (TNUM > int'(up_provider)) && (cand == '0);

    always_comb begin
      is_prov = up_valid && (int'(up_provider) == TNUM);
      we_c    = is_prov || alloc[t];
      c_in    = alloc[t] ? (up_taken ? 2'b10 : 2'b01) : ctr_step(ub_ctr[t], up_taken);
      we_u    = (is_prov && (up_pred != up_alt)) || alloc[t] || decay[t];
      u_in    = alloc[t] ? 2'b00 :
                decay[t] ? ctr_step(ub_u[t], 1'b0) :
                           ctr_step(ub_u[t], up_pred == up_taken);
    end
  end

  // longest hit provides, the previous holder becomes the alternate
  always_comb begin
    sel_pred = base_pred;
    sel_alt  = base_pred;
    sel_prov = '0;
    for (int t = 0; t < NUM_TAGGED; t++) begin
      if (lk_hit[t]) begin
        sel_alt  = sel_pred;
        sel_pred = lk_pred[t];
        sel_prov = PROV_W'(t + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_taken     <= 1'b0;
      rsp_provider  <= '0;
      rsp_alt_taken <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_taken     <= sel_pred;
        rsp_provider  <= sel_prov;
        rsp_alt_taken <= sel_alt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           ghr <= '0;
    else if (up_valid) ghr <= {ghr[GHR_W-2:0], up_taken};
  end

  // R4
  provider_range_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> int'(rsp_provider) <= NUM_TAGGED);
  // R5
  base_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_provider == '0) |-> rsp_taken == rsp_alt_taken);
  // R8
  single_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alloc));
  // R9
  decay_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (decay != '0) |-> (alloc == '0));
  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> $stable(ghr));
endmodule

// File: tb/tage_predictor_test.sv
module tage_predictor_test;
  localparam int PC_W = 10, NT = 6, IW = 4, TW = 6, BW = 5;
  localparam int D = 1 << IW;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic            lk_valid, rsp_valid, rsp_taken, rsp_alt_taken;
  logic [PC_W-1:0] lk_pc, up_pc;
  logic [2:0]      rsp_provider, up_provider;
  logic            up_valid, up_taken, up_pred, up_alt;

  tage_predictor uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .rsp_valid(rsp_valid), .rsp_taken(rsp_taken), .rsp_provider(rsp_provider),
    .rsp_alt_taken(rsp_alt_taken), .up_valid(up_valid), .up_pc(up_pc),
    .up_taken(up_taken), .up_provider(up_provider), .up_pred(up_pred), .up_alt(up_alt));

  int checks = 0, errors = 0;
  bit finished = 0;

  // arithmetic model of the tables
  logic [63:0] mghr;
  int mb [1 << BW];
  int mv [NT][D], mtg [NT][D], mc [NT][D], mu [NT][D];

  function automatic int sat(input int c, input bit up);
    return up ? ((c < 3) ? c + 1 : 3) : ((c > 0) ? c - 1 : 0);
  endfunction

  function automatic void mhash(input int n, input logic [PC_W-1:0] pc, output int idx, output int tg);
    idx = int'(pc[IW-1:0]);
    tg  = int'(pc[IW+TW-1:IW]);
    for (int k = 0; k < (1 << n); k++)
      if (mghr[k]) begin
        idx ^= 1 << (k % IW);
        tg  ^= 1 << (k % TW);
      end
  endfunction

  function automatic void mpredict(input logic [PC_W-1:0] pc, output int prov, output bit pred, output bit alt);
    int idx, tg;
    pred = mb[pc[BW-1:0]] >= 2;
    alt  = pred;
    prov = 0;
    for (int n = 1; n <= NT; n++) begin
      mhash(n, pc, idx, tg);
      if (mv[n-1][idx] != 0 && mtg[n-1][idx] == tg) begin
        alt  = pred;
        pred = mc[n-1][idx] >= 2;
        prov = n;
      end
    end
  endfunction

  function automatic void mupdate(input logic [PC_W-1:0] pc, input bit taken, input int prov,
                                  input bit pred, input bit alt);
    int ix [NT+1];
    int tg [NT+1];
    bit found = 0;
    for (int n = 1; n <= NT; n++) mhash(n, pc, ix[n], tg[n]);
    if (prov == 0) mb[pc[BW-1:0]] = sat(mb[pc[BW-1:0]], taken);
    else begin
      mc[prov-1][ix[prov]] = sat(mc[prov-1][ix[prov]], taken);
      if (pred != alt) mu[prov-1][ix[prov]] = sat(mu[prov-1][ix[prov]], pred == taken);
    end
    if (pred != taken && prov < NT) begin
      for (int n = prov + 1; n <= NT; n++)
        if (!found && (mv[n-1][ix[n]] == 0 || mu[n-1][ix[n]] == 0)) begin
          mv[n-1][ix[n]] = 1; mtg[n-1][ix[n]] = tg[n];
          mc[n-1][ix[n]] = taken ? 2 : 1; mu[n-1][ix[n]] = 0;
          found = 1;
        end
      if (!found)
        for (int n = prov + 1; n <= NT; n++) mu[n-1][ix[n]] = sat(mu[n-1][ix[n]], 1'b0);
    end
    mghr = {mghr[62:0], taken};
  endfunction

  task automatic branch(input logic [PC_W-1:0] pc, input bit taken, input string tag);
    int ep; bit epred, ealt;
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc;
    mpredict(pc, ep, epred, ealt);
    @(negedge clk);
    lk_valid = 1'b0;
    checks++;
    if (!(rsp_valid && rsp_taken == epred && int'(rsp_provider) == ep && rsp_alt_taken == ealt)) begin
      errors++;
      $display("FAIL %s pc=%h: actual v=%0b pred=%0b prov=%0d alt=%0b expected v=1 pred=%0b prov=%0d alt=%0b",
               tag, pc, rsp_valid, rsp_taken, rsp_provider, rsp_alt_taken, epred, ep, ealt);
    end
    up_valid = 1'b1; up_pc = pc; up_taken = taken;
    up_provider = 3'(ep); up_pred = epred; up_alt = ealt;
    mupdate(pc, taken, ep, epred, ealt);
    @(negedge clk);
    up_valid = 1'b0;
    // R11: no lookup was issued in the previous cycle
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 idle: actual rsp_valid=%0b expected 0", rsp_valid);
    end
  endtask

  initial begin
    logic [15:0] lf = 16'hACE1;
    logic [PC_W-1:0] pcs [4];
    pcs[0] = 10'h011; pcs[1] = 10'h2A2; pcs[2] = 10'h155; pcs[3] = 10'h3F0;
    lk_valid = 0; lk_pc = '0; up_valid = 0; up_pc = '0; up_taken = 0;
    up_provider = '0; up_pred = 0; up_alt = 0;
    mghr = '0;
    for (int i = 0; i < (1 << BW); i++) mb[i] = 1;
    for (int n = 0; n < NT; n++)
      for (int i = 0; i < D; i++) begin mv[n][i] = 0; mtg[n][i] = 0; mc[n][i] = 0; mu[n][i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual rsp_valid=%0b expected 0", rsp_valid);
    end
    // R1 first lookup sees only the reset base counter
    branch(10'h040, 1'b1, "R1 R2 reset-state");
    // R2 R6 R8 single always-taken branch
    for (int it = 0; it < 600; it++) branch(10'h040, 1'b1, "R2 R6 R8 always-taken");
    // R3 R4 alternating branch
    for (int it = 0; it < 800; it++) branch(10'h123, it[0], "R3 R4 R10 alternating");
    // R5 R7 interleaved period-three branches
    for (int it = 0; it < 1200; it++) branch(pcs[it % 4], ((it / 4) % 3) == 0, "R5 R7 period-three");
    // R8 R9 pseudo-random stream
    for (int it = 0; it < 1500; it++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      branch(lf[PC_W-1:0], lf[11], "R8 R9 random");
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule